// File: doc/BRIEF.md
# Bit-Serial Pipelined Fractional Divider

The block divides one 20-bit two's complement fraction by another and streams operands and results one bit per clock. A word lasts 20 clocks. A strobe marks the first bit of each word. Both operands arrive least significant bit first on two serial lines during one word. Over the next word the quotient is built by a non-restoring iteration. During the word after that, the quotient is sent out least significant bit first on a single line. A new operand pair may arrive in every word, so after the pipeline fills there is one quotient per word.

Three word-wide stages hold the data: an input shifter pair, the working divider state and an output shifter. These let input transfer, division and output transfer overlap. The iteration works on operand magnitudes. A final correction gives the quotient the sign implied by the operands. A fractional result only exists when the dividend is smaller in magnitude than the divisor. In every other case, and for a zero divisor, an overflow flag is raised and the output is saturated to the largest value of the correct sign.

Top module: `serial_frac_divider`

## Requirements
- R1: The cycle in which `word_sync` is high is bit 0 of a word. Bits 1 to 19 follow on the next 19 clocks, and words repeat every 20 clocks. Operand bit j (LSB first) is taken in bit cycle j. Serial data before the first `word_sync` after reset is never taken as an operand.
- R2: The quotient of the operands carried in word k appears on `quo_out` during word k+2, with bit j (LSB first) in bit cycle j. `ovf_out` holds one value for all 20 cycles of that word and changes only at word boundaries.
- R3: When the divisor is nonzero and |dividend| < |divisor|, the quotient is the 20-bit two's complement value trunc(dividend * 2^19 / divisor), rounded toward zero, and `ovf_out` is 0.
- R4: The quotient is negative when the operand signs differ and non-negative when they agree. A zero dividend gives quotient 0 whatever the divisor's sign.
- R5: When the divisor is nonzero and |dividend| >= |divisor|, `ovf_out` is 1. The quotient is 0x7FFFF if the signs agree and 0x80000 if they differ.
- R6: When the divisor is zero, `ovf_out` is 1. The quotient is 0x7FFFF for a non-negative dividend and 0x80000 for a negative one.
- R7: Operand pairs sent in consecutive words give correct, independent quotients in consecutive words, with no idle word between them.
- R8: After reset, `quo_out` and `ovf_out` are 0 through the first two words after the first `word_sync`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| word_sync | input | 1 | High in bit 0 of every word |
| dvd_in | input | 1 | Serial dividend, LSB first |
| dvs_in | input | 1 | Serial divisor, LSB first |
| quo_out | output | 1 | Serial quotient, LSB first, two words after its operands |
| ovf_out | output | 1 | Overflow for the quotient now being sent, held for the word |

## Verification
The hardest case to reach from the ports is the boundary between a valid quotient and overflow. This happens where the dividend magnitude is one step below the divisor or equal to it, and for the most negative operand, whose magnitude needs the full word width. The stimulus sends fixed pairs on both sides of that boundary in all four sign combinations. This includes the most negative value against itself and against -1 LSB. Those pairs are mixed with random pairs that are scaled down so the quotient stays valid. All words are sent back to back, so every result is checked while the next division and the next input transfer are in progress.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    // Default word width of the serial stream
    localparam int SFD_WORD_W = 20;

    // Whether the working stage holds a live operand pair
    typedef enum logic [0:0] {
        CORE_EMPTY = 1'b0,
        CORE_RUN   = 1'b1
    } core_state_e;

    // Result qualifiers carried next to the quotient
    typedef struct packed {
        logic ovf;
        logic neg;
    } quo_flags_t;

    // Sign of the quotient: a zero divisor takes the dividend's sign alone
    function automatic logic quot_negative(input logic dvd_sign,
                                           input logic dvs_sign,
                                           input logic dvs_zero);
        return dvs_zero ? dvd_sign : (dvd_sign ^ dvs_sign);
    endfunction

endpackage

// File: rtl/sfd_framer.sv
module sfd_framer #(
    parameter int W = sfd_pkg::SFD_WORD_W
) (
    input  logic clk,
    input  logic rst,
    input  logic word_sync,
    output logic word_end,
    output logic step_en
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] idx;
    logic          framed_q;
    logic          framed;

    // The strobe forces bit 0; otherwise the free-running count is used
    assign idx    = word_sync ? '0 : cnt_q;
    assign framed = framed_q | word_sync;

    assign word_end = framed && (idx == LAST);
    assign step_en  = framed && (idx != LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            framed_q <= 1'b0;
        end else begin
            framed_q <= framed;
            cnt_q    <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    // R1: once framed, word ends are exactly W cycles apart unless the strobe realigns
    logic [CW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)           gap_q <= '0;
        else if (word_end) gap_q <= '0;
        else if (framed)   gap_q <= gap_q + 1'b1;
    end
    p_word_period_r1: assert property (@(posedge clk) disable iff (rst)
        (framed_q && !word_sync && gap_q == CW'(W - 1)) |-> word_end);

endmodule

// File: rtl/sfd_deser.sv
module sfd_deser #(
    parameter int W = sfd_pkg::SFD_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dvd_bit,
    input  logic         dvs_bit,
    output logic [W-1:0] dvd_word,
    output logic [W-1:0] dvs_word
);
    logic [W-1:0] dvd_sr;
    logic [W-1:0] dvs_sr;

    // LSB first: each new bit enters at the top, older bits move down
    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_sr <= '0;
            dvs_sr <= '0;
        end else begin
            dvd_sr <= {dvd_bit, dvd_sr[W-1:1]};
            dvs_sr <= {dvs_bit, dvs_sr[W-1:1]};
        end
    end

    // Word as it stands once the current (last) bit is included
    assign dvd_word = {dvd_bit, dvd_sr[W-1:1]};
    assign dvs_word = {dvs_bit, dvs_sr[W-1:1]};

endmodule

// File: rtl/sfd_core.sv
module sfd_core
    import sfd_pkg::*;
#(
    parameter int W = SFD_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dvd_word,
    input  logic [W-1:0] dvs_word,
    output logic [W-1:0] res_q,
    output logic         res_ovf,
    output logic         res_valid,
    output logic         res_neg
);
    localparam int RW = W + 2;
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

    core_state_e     st_q;
    quo_flags_t      fl_q;
    logic [RW-1:0]   rem_q;
    logic [W-1:0]    dsr_q;
    logic [W-1:0]    qacc_q;

    logic [W-1:0]    dvd_mag;
    logic [W-1:0]    dvs_mag;
    logic            dvs_zero;
    logic [RW-1:0]   rem_sh;
    logic [RW-1:0]   dsr_ext;
    logic [RW-1:0]   rem_nx;

    // Magnitudes; the most negative value maps to 2^(W-1) as unsigned
    assign dvd_mag  = dvd_word[W-1] ? (~dvd_word + 1'b1) : dvd_word;
    assign dvs_mag  = dvs_word[W-1] ? (~dvs_word + 1'b1) : dvs_word;
    assign dvs_zero = (dvs_word == '0);

    // One non-restoring step: shift, then add or subtract by remainder sign
    assign rem_sh  = {rem_q[RW-2:0], 1'b0};
    assign dsr_ext = {2'b00, dsr_q};
    assign rem_nx  = rem_q[RW-1] ? (rem_sh + dsr_ext) : (rem_sh - dsr_ext);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CORE_EMPTY;
            fl_q   <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            qacc_q <= '0;
        end else if (load) begin
            st_q     <= CORE_RUN;
            rem_q    <= {2'b00, dvd_mag};
            dsr_q    <= dvs_mag;
            qacc_q   <= '0;
            fl_q.ovf <= dvs_zero || (dvd_mag >= dvs_mag);
            fl_q.neg <= quot_negative(dvd_word[W-1], dvs_word[W-1], dvs_zero);
        end else if (step && st_q == CORE_RUN && !fl_q.ovf) begin
            rem_q  <= rem_nx;
            qacc_q <= {qacc_q[W-2:0], ~rem_nx[RW-1]};
        end
    end

    // Sign correction and saturation of the finished quotient
    always_comb begin
        if (fl_q.ovf)      res_q = fl_q.neg ? NEG_MAX : POS_MAX;
        else if (fl_q.neg) res_q = ~qacc_q + 1'b1;
        else               res_q = qacc_q;
    end

    assign res_ovf   = fl_q.ovf;
    assign res_neg   = fl_q.neg;
    assign res_valid = (st_q == CORE_RUN);

    // R3: the partial remainder stays within [-D, D) throughout a valid divide
    p_rem_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == CORE_RUN && !fl_q.ovf) |->
        ($signed(rem_q) >= -$signed(dsr_ext) && $signed(rem_q) < $signed(dsr_ext)));

    // R4: a valid magnitude never reaches the sign bit, so negation is exact
    p_qmag_r4: assert property (@(posedge clk) disable iff (rst)
        (load && st_q == CORE_RUN && !fl_q.ovf) |-> (qacc_q[W-1] == 1'b0));

endmodule

// File: rtl/sfd_ser.sv
module sfd_ser #(
    parameter int W = sfd_pkg::SFD_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         res_valid,
    input  logic [W-1:0] res_q,
    input  logic         res_ovf,
    input  logic         res_neg,
    output logic         q_bit,
    output logic         ovf_flag
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] out_sr;
    logic         ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sr <= '0;
            ovf_q  <= 1'b0;
        end else if (load) begin
            out_sr <= res_valid ? res_q : '0;
            ovf_q  <= res_valid && res_ovf;
        end else begin
            out_sr <= {1'b0, out_sr[W-1:1]};
        end
    end

    assign q_bit    = out_sr[0];
    assign ovf_flag = ovf_q;

    // R5: an overflowed result always leaves as one of the two saturation words
    p_sat_word_r5: assert property (@(posedge clk) disable iff (rst)
        (load && res_valid && res_ovf) |=> (out_sr == POS_MAX || out_sr == NEG_MAX));

    // R4: a nonzero valid quotient carries the sign decided from the operands
    p_quot_sign_r4: assert property (@(posedge clk) disable iff (rst)
        (load && res_valid && !res_ovf && res_q != '0) |=> (out_sr[W-1] == $past(res_neg)));

endmodule

// File: rtl/serial_frac_divider.sv
module serial_frac_divider
    import sfd_pkg::*;
#(
    parameter int W = SFD_WORD_W
) (
    input  logic clk,
    input  logic rst,
    input  logic word_sync,
    input  logic dvd_in,
    input  logic dvs_in,
    output logic quo_out,
    output logic ovf_out
);
    logic         word_end;
    logic         step_en;
    logic [W-1:0] dvd_word;
    logic [W-1:0] dvs_word;
    logic [W-1:0] res_q;
    logic         res_ovf;
    logic         res_valid;
    logic         res_neg;

    sfd_framer #(.W(W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .word_sync (word_sync),
        .word_end  (word_end),
        .step_en   (step_en)
    );

    sfd_deser #(.W(W)) u_deser (
        .clk      (clk),
        .rst      (rst),
        .dvd_bit  (dvd_in),
        .dvs_bit  (dvs_in),
        .dvd_word (dvd_word),
        .dvs_word (dvs_word)
    );

    sfd_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load      (word_end),
        .step      (step_en),
        .dvd_word  (dvd_word),
        .dvs_word  (dvs_word),
        .res_q     (res_q),
        .res_ovf   (res_ovf),
        .res_valid (res_valid),
        .res_neg   (res_neg)
    );

    sfd_ser #(.W(W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (word_end),
        .res_valid (res_valid),
        .res_q     (res_q),
        .res_ovf   (res_ovf),
        .res_neg   (res_neg),
        .q_bit     (quo_out),
        .ovf_flag  (ovf_out)
    );

    // R2: the overflow flag moves only on the clock that closes a word
    p_ovf_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !word_end |=> $stable(ovf_out));

    // R8: nothing leaves before two word ends have occurred
    logic [1:0] words_seen_q;
    always_ff @(posedge clk) begin
        if (rst)                                 words_seen_q <= '0;
        else if (word_end && words_seen_q != 2'd2) words_seen_q <= words_seen_q + 1'b1;
    end
    p_idle_out_r8: assert property (@(posedge clk) disable iff (rst)
        (words_seen_q != 2'd2) |-> (!quo_out && !ovf_out));

endmodule

// File: tb/serial_frac_divider_bench.sv
module serial_frac_divider_bench;

    localparam int W = 20;

    typedef struct {
        int          k;
        logic [W-1:0] q;
        logic        ovf;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_sync = 1'b0;
    logic dvd_in = 1'b0;
    logic dvs_in = 1'b0;
    logic quo_out;
    logic ovf_out;

    int checks = 0;
    int errors = 0;
    int words_sent = 0;
    bit done = 1'b0;
    bit reported = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    serial_frac_divider u_serial_frac_divider (
        .clk       (clk),
        .rst       (rst),
        .word_sync (word_sync),
        .dvd_in    (dvd_in),
        .dvs_in    (dvs_in),
        .quo_out   (quo_out),
        .ovf_out   (ovf_out)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    // Reference model written from R3..R6
    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b);
        exp_t e;
        longint as, bs, aa, ab, q;
        as = longint'($signed(a));
        bs = longint'($signed(b));
        aa = (as < 0) ? -as : as;
        ab = (bs < 0) ? -bs : bs;
        if (bs == 0) begin
            e.ovf = 1'b1;
            e.q   = (as < 0) ? 20'h80000 : 20'h7FFFF;
            e.tag = "R6";
        end else if (aa >= ab) begin
            e.ovf = 1'b1;
            e.q   = ((as < 0) != (bs < 0)) ? 20'h80000 : 20'h7FFFF;
            e.tag = "R5";
        end else begin
            q     = (as * (longint'(1) << (W - 1))) / bs;
            e.ovf = 1'b0;
            e.q   = q[W-1:0];
            e.tag = (as != 0 && ((as < 0) != (bs < 0))) ? "R4" : "R3";
        end
        return e;
    endfunction

    // Driver: one word of operands, expected result pushed to the scoreboard
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b);
        exp_t e;
        e   = model(a, b);
        e.k = words_sent;
        exp_q.push_back(e);
        words_sent++;
        for (int j = 0; j < W; j++) begin
            @(negedge clk);
            word_sync = (j == 0);
            dvd_in    = a[j];
            dvs_in    = b[j];
        end
    endtask

    // Monitor: gathers each output word and compares it with the scoreboard
    initial begin
        int           w = 0;
        int           bi = -1;
        logic [W-1:0] cap = '0;
        logic         ovf0 = 1'b0;
        bit           ovf_moved = 1'b0;
        exp_t         e;
        forever begin
            @(negedge clk);
            #1;
            if (rst) continue;
            if (word_sync) bi = 0;
            else if (bi >= 0) bi = bi + 1;
            if (bi >= 0) begin
                cap[bi] = quo_out;
                if (bi == 0) begin
                    ovf0 = ovf_out;
                    ovf_moved = 1'b0;
                end else if (ovf_out != ovf0) begin
                    ovf_moved = 1'b1;
                end
                if (bi == W - 1) begin
                    if (w < 2) begin
                        // R8: pipeline still filling, outputs stay at zero
                        check(cap == '0 && !ovf0, "R8 idle quotient", cap, '0);
                    end else if (exp_q.size() != 0 && exp_q[0].k == w - 2) begin
                        e = exp_q.pop_front();
                        // R2: quotient of word k in word k+2, overflow held for the word
                        check(cap == e.q, {e.tag, " quotient (R2 R7 timing)"}, cap, e.q);
                        check(ovf0 == e.ovf && !ovf_moved, {e.tag, " overflow flag R2"},
                              {19'd0, ovf0}, {19'd0, e.ovf});
                    end
                    w++;
                    bi = -1;
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [W-1:0] ra, rb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1, R8: serial junk before the first strobe is not taken
        for (int j = 0; j < 7; j++) begin
            @(negedge clk);
            dvd_in = 1'b1;
            dvs_in = 1'b0;
            #1;
            check(!quo_out && !ovf_out, "R8 reset outputs", {19'd0, quo_out}, '0);
        end
        // R3 and R4: valid quotients, all sign combinations
        send(20'h20000, 20'h40000);
        send(20'hE0000, 20'h40000);
        send(20'h20000, 20'hC0000);
        send(20'hE0000, 20'hC0000);
        send(20'h00000, 20'hEDCBB);
        send(20'h00001, 20'h7FFFF);
        send(20'h3FFFF, 20'h40000);
        send(20'hFFFFF, 20'h80000);
        send(20'h7FFFE, 20'h80000);
        // R5: magnitude at or above the divisor
        send(20'h40000, 20'h40000);
        send(20'hC0000, 20'h40000);
        send(20'h80000, 20'h80000);
        send(20'h7FFFF, 20'h00001);
        send(20'h40000, 20'hC0000);
        // R6: zero divisor
        send(20'h00005, 20'h00000);
        send(20'hFFFFB, 20'h00000);
        send(20'h00000, 20'h00000);
        // R7: random back-to-back words with a mostly valid quotient
        for (int n = 0; n < 24; n++) begin
            ra = W'($urandom);
            rb = W'($urandom);
            ra = W'($signed(ra) >>> (n % 5 + 1));
            send(ra, rb);
        end
        // Flush the pipeline with two extra words
        send(20'h00000, 20'h00001);
        send(20'h00000, 20'h00001);
        @(negedge clk);
        word_sync = 1'b0;
        repeat (2 * W + 5) @(negedge clk);
        // Every word except the last two flush words must have been compared
        check(exp_q.size() <= 2, "R7 scoreboard drained", W'(exp_q.size()), W'(2));
        done = 1'b1;
        report();
        $finish;
    end

endmodule